// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides, each clock cycle, whether a pending interrupt should be taken by the core. It looks at two request sources. The first is a software request word, whose request bits sit in a contiguous field. The second is an external status vector. Each source places its set bits onto one shared 5-bit priority level scale, using its own mapping. The highest resulting level is compared with the core's current priority level, and the block raises a one-cycle trap request when that level is strictly higher.

When an interrupt is taken, the winning level and a bitmask of every pending in-range request are registered for the interrupt ID and interrupt summary registers. Both values hold until the next interrupt is taken. After a trap request, the block stays quiet until the core acknowledges it, so one request can never trigger two traps. A nonzero asynchronous-trap request word is not supported, and the block reports it on an error output.

Top module: `irq_level_eval`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `trap_req_o`, `int_id_o`, `int_sum_o` and `ast_err_o` are all zero.
- R2: A set bit b of `sw_req_i` with 4 <= b <= 18 requests level b-3 (bit 4 is level 1, bit 18 is level 15). Bits of `sw_req_i` outside 4..18 have no effect on the level or the summary.
- R3: A set bit b of `ext_stat_i` with 20 <= b <= 30 requests level b. Bits of `ext_stat_i` outside 20..30 have no effect on the level or the summary.
- R4: The highest requested level wins. Any in-range external request overrides every software request, whatever its bit position.
- R5: The latched summary is the OR of all in-range pending bits of both sources, each at its own bit position, and not only the winning bit.
- R6: An interrupt is taken only when the winning level is nonzero and strictly greater than `cur_ipl_i`, compared as unsigned 5-bit values. An equal level is not taken.
- R7: When an interrupt is taken, `trap_req_o` is high for exactly the next cycle. In that same cycle, `int_id_o` and `int_sum_o` show the level and summary computed from the inputs of the taking cycle. Both hold their values until the next interrupt is taken.
- R8: After a trap request, no further request is taken until `trap_ack_i` is sampled high on a clock edge. That edge may fall in the pulse cycle or any later cycle, and taking resumes in the following cycle. An acknowledge with nothing outstanding has no effect.
- R9: `ast_err_o` is high in the cycle after any cycle in which `ast_req_i` is nonzero, and low after a cycle in which it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 32 | Software interrupt request word |
| ext_stat_i | input | 32 | External interrupt status vector |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| ast_req_i | input | 4 | Asynchronous-trap request word |
| trap_ack_i | input | 1 | Core acknowledge of the outstanding trap request |
| trap_req_o | output | 1 | One-cycle interrupt trap request |
| int_id_o | output | 5 | Level of the last interrupt taken |
| int_sum_o | output | 32 | Pending-request summary of the last interrupt taken |
| ast_err_o | output | 1 | Unsupported asynchronous-trap request seen |

## Verification
The bench builds the block with its default parameters. These are a 32-bit request width, a software field on bits 4 to 18 with rebasing to levels 1 to 15, and an external field on bits 20 to 30 that maps one to one. With these values, both ends of each field are reachable, along with the unused bits 3, 19 and 31 that must be ignored. The bench also reaches the highest level, 30, against a current level of 31, so the strict, unsigned comparison is exercised at the top of the 5-bit scale. Scenarios that hold a request without an acknowledge, then acknowledge in the pulse cycle or later, cover the lockout window.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

    localparam int LVL_W = 5;

    typedef logic [LVL_W-1:0] lvl_t;

    // outcome of scanning one request source
    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } lvl_pick_t;

    // decision produced by the comparator stage
    typedef struct packed {
        logic take;
        lvl_t lvl;
    } lvl_decision_t;

    // level assigned to request bit bit_idx of a field starting at base
    function automatic lvl_t map_level(input int bit_idx, input int base, input bit rebase);
        if (rebase)
            return lvl_t'(bit_idx - base + 1);
        else
            return lvl_t'(bit_idx);
    endfunction

endpackage

// File: rtl/irq_range_scan.sv
module irq_range_scan
    import irq_eval_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int LO     = 4,
    parameter int HI     = 18,
    parameter bit REBASE = 1'b1
) (
    input  logic [VEC_W-1:0] req_i,
    output lvl_pick_t        pick_o,
    output logic [VEC_W-1:0] mask_o
);

    // keep only the bits inside the field
    for (genvar b = 0; b < VEC_W; b++) begin : g_mask
        if (b >= LO && b <= HI) begin : g_in
            assign mask_o[b] = req_i[b];
        end else begin : g_out
            assign mask_o[b] = 1'b0;
        end
    end

    // ascending scan: the last set bit seen decides the level
    always_comb begin
        pick_o = '0;
        for (int i = LO; i <= HI; i++) begin
            if (req_i[i]) begin
                pick_o.hit = 1'b1;
                pick_o.lvl = map_level(i, LO, REBASE);
            end
        end
    end

endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
    import irq_eval_pkg::*;
(
    input  lvl_pick_t     sw_pick_i,
    input  lvl_pick_t     ext_pick_i,
    input  lvl_t          cur_ipl_i,
    input  logic          busy_i,
    output lvl_decision_t dec_o
);

    lvl_pick_t winner;

    // any external request outranks every software request
    always_comb begin
        winner = ext_pick_i.hit ? ext_pick_i : sw_pick_i;
        dec_o.lvl  = winner.lvl;
        dec_o.take = winner.hit && (winner.lvl != '0) &&
                     (winner.lvl > cur_ipl_i) && !busy_i;
    end

endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import irq_eval_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 30,
    parameter int AST_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VEC_W-1:0] sw_req_i,
    input  logic [VEC_W-1:0] ext_stat_i,
    input  logic [LVL_W-1:0] cur_ipl_i,
    input  logic [AST_W-1:0] ast_req_i,
    input  logic             trap_ack_i,
    output logic             trap_req_o,
    output logic [LVL_W-1:0] int_id_o,
    output logic [VEC_W-1:0] int_sum_o,
    output logic             ast_err_o
);

    lvl_pick_t        sw_pick, ext_pick;
    logic [VEC_W-1:0] sw_mask, ext_mask, sum_now;
    lvl_decision_t    dec;

    logic             trap_q, busy_q, err_q;
    lvl_t             id_q;
    logic [VEC_W-1:0] sum_q;

    irq_range_scan #(
        .VEC_W(VEC_W), .LO(SW_LO), .HI(SW_HI), .REBASE(1'b1)
    ) sw_scan_i (
        .req_i(sw_req_i), .pick_o(sw_pick), .mask_o(sw_mask)
    );

    irq_range_scan #(
        .VEC_W(VEC_W), .LO(EXT_LO), .HI(EXT_HI), .REBASE(1'b0)
    ) ext_scan_i (
        .req_i(ext_stat_i), .pick_o(ext_pick), .mask_o(ext_mask)
    );

    irq_level_cmp cmp_i (
        .sw_pick_i(sw_pick), .ext_pick_i(ext_pick),
        .cur_ipl_i(cur_ipl_i), .busy_i(busy_q), .dec_o(dec)
    );

    assign sum_now = sw_mask | ext_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            id_q   <= '0;
            sum_q  <= '0;
        end else begin
            trap_q <= dec.take;
            err_q  <= |ast_req_i;
            if (dec.take)
                busy_q <= 1'b1;
            else if (trap_ack_i)
                busy_q <= 1'b0;
            if (dec.take) begin
                id_q  <= dec.lvl;
                sum_q <= sum_now;
            end
        end
    end

    assign trap_req_o = trap_q;
    assign int_id_o   = id_q;
    assign int_sum_o  = sum_q;
    assign ast_err_o  = err_q;

endmodule

// File: rtl/irq_level_eval_chk.sv
module irq_level_eval_chk #(
    parameter int VEC_W  = 32,
    parameter int EXT_LO = 20,
    parameter int AST_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       cur_ipl_i,
    input logic [AST_W-1:0] ast_req_i,
    input logic             trap_req_o,
    input logic [4:0]       int_id_o,
    input logic [VEC_W-1:0] int_sum_o,
    input logic             ast_err_o
);

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |=> !trap_req_o);

    p_level_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |-> int_id_o != 5'd0);

    p_level_above_ipl_r6: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |-> int_id_o > $past(cur_ipl_i));

    p_id_holds_r7: assert property (@(posedge clk) disable iff (rst)
        !trap_req_o |-> $stable(int_id_o) && $stable(int_sum_o));

    p_ext_winner_in_sum_r5: assert property (@(posedge clk) disable iff (rst)
        (trap_req_o && int_id_o >= EXT_LO) |-> int_sum_o[int_id_o]);

    p_ast_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (|ast_req_i) |=> ast_err_o);

endmodule

bind irq_level_eval irq_level_eval_chk #(
    .VEC_W(VEC_W), .EXT_LO(EXT_LO), .AST_W(AST_W)
) chk_i (
    .clk(clk), .rst(rst), .cur_ipl_i(cur_ipl_i), .ast_req_i(ast_req_i),
    .trap_req_o(trap_req_o), .int_id_o(int_id_o), .int_sum_o(int_sum_o),
    .ast_err_o(ast_err_o)
);

// File: tb/irq_level_eval_tb_top.sv
module irq_level_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sw_req_i = '0;
    logic [31:0] ext_stat_i = '0;
    logic [4:0]  cur_ipl_i = '0;
    logic [3:0]  ast_req_i = '0;
    logic        trap_ack_i = 1'b0;
    logic        trap_req_o;
    logic [4:0]  int_id_o;
    logic [31:0] int_sum_o;
    logic        ast_err_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    irq_level_eval dut_i (
        .clk(clk), .rst(rst), .sw_req_i(sw_req_i), .ext_stat_i(ext_stat_i),
        .cur_ipl_i(cur_ipl_i), .ast_req_i(ast_req_i), .trap_ack_i(trap_ack_i),
        .trap_req_o(trap_req_o), .int_id_o(int_id_o), .int_sum_o(int_sum_o),
        .ast_err_o(ast_err_o)
    );

    typedef struct {
        logic        trap;
        logic [4:0]  id;
        logic [31:0] sum;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];

    // reference state built from the requirements
    logic        m_pend = 1'b0;
    logic [4:0]  m_id   = '0;
    logic [31:0] m_sum  = '0;

    task automatic step(input logic [31:0] sw, input logic [31:0] ext,
                        input logic [4:0] ipl, input logic [3:0] ast,
                        input logic ack, input string tag);
        exp_t        e;
        int          lvl;
        logic [31:0] s;
        logic        take;
        @(negedge clk);
        sw_req_i = sw; ext_stat_i = ext; cur_ipl_i = ipl;
        ast_req_i = ast; trap_ack_i = ack;
        lvl = 0; s = '0;
        for (int b = 4; b <= 18; b++)
            if (sw[b]) begin lvl = b - 3; s[b] = 1'b1; end
        for (int b = 20; b <= 30; b++)
            if (ext[b]) begin lvl = b; s[b] = 1'b1; end
        take = (lvl != 0) && (lvl > int'(ipl)) && !m_pend;
        if (take) begin
            m_id  = 5'(lvl);
            m_sum = s;
        end
        m_pend = take ? 1'b1 : (ack ? 1'b0 : m_pend);
        e.trap = take; e.id = m_id; e.sum = m_sum; e.err = |ast; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic clear_all(input string tag);
        step('0, '0, 5'd0, 4'd0, 1'b1, tag);
    endtask

    // monitor: compares one expected item per cycle, mid-high-phase
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                total++;
                if (trap_req_o !== e.trap || int_id_o !== e.id ||
                    int_sum_o !== e.sum || ast_err_o !== e.err) begin
                    bad++;
                    $display("FAIL %s: got trap=%0b id=%0d sum=%h err=%0b exp trap=%0b id=%0d sum=%h err=%0b",
                             e.tag, trap_req_o, int_id_o, int_sum_o, ast_err_o,
                             e.trap, e.id, e.sum, e.err);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs zero under reset, with requests present
        sw_req_i = 32'h0007_fff0; ext_stat_i = 32'h7ff0_0000; ast_req_i = 4'hf;
        repeat (3) @(negedge clk);
        total++;
        if (trap_req_o !== 1'b0 || int_id_o !== 5'd0 || int_sum_o !== '0 || ast_err_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: got trap=%0b id=%0d sum=%h err=%0b exp all zero",
                     trap_req_o, int_id_o, int_sum_o, ast_err_o);
        end
        sw_req_i = '0; ext_stat_i = '0; ast_req_i = '0;
        rst = 1'b0;
        step('0, '0, 5'd0, 4'd0, 1'b0, "R1");

        // R2: software field ends
        step(32'h0000_0010, '0, 5'd0, 4'd0, 1'b0, "R2");
        clear_all("R8");
        step(32'h0004_0000, '0, 5'd0, 4'd0, 1'b0, "R2");
        clear_all("R8");
        step(32'h8008_0008, '0, 5'd0, 4'd0, 1'b0, "R2");
        step('0, '0, 5'd0, 4'd0, 1'b0, "R7");

        // R3: external field ends and ignored neighbours
        step('0, 32'h0010_0000, 5'd0, 4'd0, 1'b0, "R3");
        clear_all("R8");
        step('0, 32'h4000_0000, 5'd0, 4'd0, 1'b0, "R3");
        clear_all("R8");
        step('0, 32'h8008_0000, 5'd0, 4'd0, 1'b0, "R3");

        // R4, R5: mix of sources, summary covers all
        step(32'h0000_0420, 32'h0240_0000, 5'd0, 4'd0, 1'b0, "R4");
        clear_all("R8");
        step(32'h0004_0000, 32'h0010_0000, 5'd0, 4'd0, 1'b0, "R5");
        clear_all("R8");

        // R6: strict comparison
        step(32'h0000_0100, '0, 5'd5, 4'd0, 1'b0, "R6");
        step(32'h0000_0100, '0, 5'd4, 4'd0, 1'b0, "R6");
        clear_all("R8");
        step('0, 32'h4000_0000, 5'd31, 4'd0, 1'b0, "R6");
        step('0, 32'h4000_0000, 5'd30, 4'd0, 1'b0, "R6");
        step('0, 32'h4000_0000, 5'd29, 4'd0, 1'b0, "R6");

        // R7, R8: held request, no acknowledge, then acknowledge later
        step('0, 32'h4000_0000, 5'd29, 4'd0, 1'b0, "R8");
        step('0, 32'h4000_0000, 5'd29, 4'd0, 1'b0, "R8");
        step('0, 32'h4000_0000, 5'd29, 4'd0, 1'b1, "R8");
        step('0, 32'h4000_0000, 5'd29, 4'd0, 1'b0, "R8");
        // acknowledge in the pulse cycle
        step('0, 32'h4000_0000, 5'd29, 4'd1, 1'b1, "R8");
        step(32'h0000_0010, '0, 5'd0, 4'd0, 1'b0, "R7");
        clear_all("R8");
        // stray acknowledge with nothing outstanding
        step('0, '0, 5'd0, 4'd0, 1'b1, "R8");
        step(32'h0000_0020, '0, 5'd0, 4'd0, 1'b0, "R8");
        clear_all("R8");

        // R9: asynchronous-trap flag
        step('0, '0, 5'd0, 4'd8, 1'b0, "R9");
        step('0, '0, 5'd0, 4'd0, 1'b0, "R9");
        step('0, '0, 5'd0, 4'd1, 1'b0, "R9");
        step('0, '0, 5'd0, 4'd0, 1'b0, "R9");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule